// File: doc/BRIEF.md
# Wake Event Reporter

This block gathers wake events for a fixed set of channel slots and hands them to a host driver as a list read through one register port. Each slot has three event strobes: readable, writable and closed. Readable and writable events are kept only when the host has armed that slot for them beforehand. Closed events are kept whenever they arrive. Kept events wait in a per-slot mask. Events that hit one slot before it is reported merge into a single entry.

While anything is waiting, or a list read is in progress, the interrupt line is high. The driver then reads the channel register over and over. Each read returns the identifier of the lowest-numbered waiting slot, which is the slot index plus one, and takes that slot off the list. A read of the wakes register then returns the mask that was taken. A channel value of zero ends the list. Events that arrive while a list is being read are held back. They go back to the waiting set only after that list ends.

The read port is a plain request/response port with no back-pressure. Every `rd_en` is served, and the response appears with `rsp_valid` on the next cycle.

Top module: `wake_event_reporter`

## Requirements
- R1: After reset, `irq` and `rsp_valid` are low, and a channel read returns 0.
- R2: A channel read (`rd_sel`=0) returns slot index + 1 for the lowest-indexed slot that has a non-empty mask. Slots are returned in ascending order as the list is drained.
- R3: A wakes read (`rd_sel`=1) returns the mask taken by the most recent channel read, in bits [2:0]: bit 0 readable, bit 1 writable, bit 2 closed. All higher bits read as zero.
- R4: A channel read returns 0 when no slot in the current list has a mask left. A wakes read after that returns 0.
- R5: A readable or writable strobe on a slot that is not armed for it is dropped. It raises no interrupt and produces no list entry.
- R6: A closed strobe is always recorded, with or without arming. The cycle after it, `irq` is high.
- R7: Arming is one-shot. Once an armed readable or writable event has been accepted, a later event of the same kind is dropped until the slot is armed again.
- R8: Several events on one slot before it is reported merge into one list entry whose mask is their OR.
- R9: `irq` is high while any slot has a mask or a list is being drained. It is low after the terminating zero has been read with nothing waiting.
- R10: An event that arrives after the first non-zero channel read of a list is not reported in that list. It is reported after the terminating zero, and `irq` stays high.
- R11: `rsp_valid` is high exactly one cycle after each cycle with `rd_en` high, and low otherwise.
- R12: An arm strobe and a matching event in the same cycle count as armed. The event is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_readable | input | NUM_SLOTS | Per-slot strobe: slot became readable |
| evt_writable | input | NUM_SLOTS | Per-slot strobe: slot became writable |
| evt_closed | input | NUM_SLOTS | Per-slot strobe: service closed the slot |
| arm_on_read | input | NUM_SLOTS | Per-slot strobe: request a wake on readability |
| arm_on_write | input | NUM_SLOTS | Per-slot strobe: request a wake on writability |
| rd_en | input | 1 | Register read request |
| rd_sel | input | 1 | 0 selects the channel register, 1 the wakes register |
| rsp_valid | output | 1 | Read response valid, one cycle after `rd_en` |
| rsp_data | output | CHAN_W | Read response data |
| irq | output | 1 | Interrupt, high while events are pending or being drained |

## Verification
The bench builds the block with NUM_SLOTS=4 and CHAN_W=32. With four slots, both the lowest and the highest slot are reached, and a full list can be drained in a few reads. This lets the tests cover ascending order, merged masks and the terminating zero. The short list also makes it easy to inject a closed event mid-drain on a slot below the one being read, which exposes any early reporting of held events.

// File: rtl/wer_pkg.sv
package wer_pkg;
  localparam int MASK_W    = 3;
  localparam int BIT_READ  = 0;
  localparam int BIT_WRITE = 1;
  localparam int BIT_CLOSE = 2;

  typedef logic [MASK_W-1:0] wake_mask_t;

  localparam logic SEL_CHAN  = 1'b0;
  localparam logic SEL_WAKES = 1'b1;
endpackage

// File: rtl/wer_slot.sv
// One slot: arming flags, pending mask and mid-drain hold mask.
module wer_slot
  import wer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_rd,
  input  logic       ev_wr,
  input  logic       ev_cls,
  input  logic       arm_rd,
  input  logic       arm_wr,
  input  logic       to_hold,
  input  logic       end_list,
  input  logic       claim,
  output wake_mask_t pend
);
  logic       armed_rd_q, armed_wr_q;
  wake_mask_t pend_q, hold_q, fresh;
  logic       gate_rd, gate_wr;

  // An arm strobe in the same cycle as the event counts.
  assign gate_rd = armed_rd_q | arm_rd;
  assign gate_wr = armed_wr_q | arm_wr;

  always_comb begin
    fresh            = '0;
    fresh[BIT_READ]  = ev_rd & gate_rd;
    fresh[BIT_WRITE] = ev_wr & gate_wr;
    fresh[BIT_CLOSE] = ev_cls;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_rd_q <= 1'b0;
      armed_wr_q <= 1'b0;
      pend_q     <= '0;
      hold_q     <= '0;
    end else begin
      // Accepting an event uses up its arming.
      armed_rd_q <= gate_rd & ~ev_rd;
      armed_wr_q <= gate_wr & ~ev_wr;
      if (end_list) begin
        pend_q <= hold_q | fresh;
        hold_q <= '0;
      end else if (to_hold) begin
        hold_q <= hold_q | fresh;
        pend_q <= claim ? '0 : pend_q;
      end else begin
        pend_q <= pend_q | fresh;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/wer_pick.sv
// Lowest-index finder over a request vector.
module wer_pick #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wer_regport.sv
// Registered read response for the channel and wakes registers.
module wer_regport
  import wer_pkg::*;
#(
  parameter int CHAN_W = 32,
  parameter int IW     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_sel,
  input  logic              found,
  input  logic [IW-1:0]     idx,
  input  wake_mask_t        pick_mask,
  output logic              rsp_valid,
  output logic [CHAN_W-1:0] rsp_data
);
  wake_mask_t        cur_mask_q;
  logic [CHAN_W-1:0] chan_val;

  assign chan_val = found ? (CHAN_W'(idx) + CHAN_W'(1)) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      cur_mask_q <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) begin
        if (rd_sel == SEL_CHAN) begin
          rsp_data   <= chan_val;
          cur_mask_q <= found ? pick_mask : '0;
        end else begin
          rsp_data <= CHAN_W'(cur_mask_q);
        end
      end
    end
  end
endmodule

// File: rtl/wake_event_reporter.sv
module wake_event_reporter
  import wer_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int CHAN_W    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] evt_readable,
  input  logic [NUM_SLOTS-1:0] evt_writable,
  input  logic [NUM_SLOTS-1:0] evt_closed,
  input  logic [NUM_SLOTS-1:0] arm_on_read,
  input  logic [NUM_SLOTS-1:0] arm_on_write,
  input  logic                 rd_en,
  input  logic                 rd_sel,
  output logic                 rsp_valid,
  output logic [CHAN_W-1:0]    rsp_data,
  output logic                 irq
);
  localparam int IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  wake_mask_t           pend [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] nz;
  logic [NUM_SLOTS-1:0] claim;
  logic                 found;
  logic [IW-1:0]        idx;
  wake_mask_t           pick_mask;
  logic                 draining_q;
  logic                 chan_read, start_drain, end_list, to_hold;

  assign chan_read   = rd_en & (rd_sel == SEL_CHAN);
  assign start_drain = chan_read & found & ~draining_q;
  assign end_list    = chan_read & ~found & draining_q;
  assign to_hold     = draining_q | start_drain;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    assign claim[s] = chan_read & found & (idx == IW'(s));
    assign nz[s]    = |pend[s];
    wer_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev_rd    (evt_readable[s]),
      .ev_wr    (evt_writable[s]),
      .ev_cls   (evt_closed[s]),
      .arm_rd   (arm_on_read[s]),
      .arm_wr   (arm_on_write[s]),
      .to_hold  (to_hold),
      .end_list (end_list),
      .claim    (claim[s]),
      .pend     (pend[s])
    );
  end

  wer_pick #(.N(NUM_SLOTS), .IW(IW)) u_pick (
    .req   (nz),
    .found (found),
    .idx   (idx)
  );

  always_comb begin
    pick_mask = '0;
    for (int s = 0; s < NUM_SLOTS; s++) begin
      if (idx == IW'(s)) pick_mask = pend[s];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)           draining_q <= 1'b0;
    else if (start_drain) draining_q <= 1'b1;
    else if (end_list)    draining_q <= 1'b0;
  end

  assign irq = draining_q | (|nz);

  wer_regport #(.CHAN_W(CHAN_W), .IW(IW)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_en     (rd_en),
    .rd_sel    (rd_sel),
    .found     (found),
    .idx       (idx),
    .pick_mask (pick_mask),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );
endmodule

// File: rtl/wer_checker.sv
module wer_checker #(
  parameter int NUM_SLOTS = 8,
  parameter int CHAN_W    = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_SLOTS-1:0] evt_closed,
  input logic                 rd_en,
  input logic                 rd_sel,
  input logic                 rsp_valid,
  input logic [CHAN_W-1:0]    rsp_data,
  input logic                 irq
);
  assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rsp_valid);
  assert_rsp_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rsp_valid);
  assert_chan_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rd_sel) == 1'b0) |-> rsp_data <= CHAN_W'(NUM_SLOTS));
  assert_mask_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rd_sel) == 1'b1) |-> rsp_data[CHAN_W-1:3] == '0);
  assert_irq_in_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && $past(rd_sel) == 1'b0 && rsp_data != '0) |-> irq);
  assert_close_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_closed) |=> irq);
endmodule

bind wake_event_reporter wer_checker #(.NUM_SLOTS(NUM_SLOTS), .CHAN_W(CHAN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .evt_closed (evt_closed),
  .rd_en      (rd_en),
  .rd_sel     (rd_sel),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .irq        (irq)
);

// File: tb/wake_event_reporter_bench.sv
module wake_event_reporter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int CW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_readable = '0, evt_writable = '0, evt_closed = '0;
  logic [N-1:0]  arm_on_read = '0, arm_on_write = '0;
  logic          rd_en = 1'b0, rd_sel = 1'b0;
  logic          rsp_valid;
  logic [CW-1:0] rsp_data;
  logic          irq;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wake_event_reporter #(.NUM_SLOTS(N), .CHAN_W(CW)) u_wake_event_reporter (
    .clk(clk), .rst_n(rst_n),
    .evt_readable(evt_readable), .evt_writable(evt_writable), .evt_closed(evt_closed),
    .arm_on_read(arm_on_read), .arm_on_write(arm_on_write),
    .rd_en(rd_en), .rd_sel(rd_sel),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a one-cycle strobe set, then clear.
  task automatic pulse(input logic [N-1:0] rd, input logic [N-1:0] wr, input logic [N-1:0] cl,
                       input logic [N-1:0] ar, input logic [N-1:0] aw);
    @(negedge clk);
    evt_readable = rd; evt_writable = wr; evt_closed = cl;
    arm_on_read = ar; arm_on_write = aw;
    @(negedge clk);
    evt_readable = '0; evt_writable = '0; evt_closed = '0;
    arm_on_read = '0; arm_on_write = '0;
  endtask

  task automatic rd_reg(input logic sel, output logic [CW-1:0] data);
    @(negedge clk);
    rd_en = 1'b1; rd_sel = sel;
    @(negedge clk);
    rd_en = 1'b0;
    data = rsp_data;
    check(rsp_valid == 1'b1, "R11 valid after read", rsp_valid, 1);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R11 valid drops", rsp_valid, 0);
  endtask

  task automatic expect_chan(input int exp, input string req);
    logic [CW-1:0] d;
    rd_reg(1'b0, d);
    check(d == CW'(exp), req, d, exp);
  endtask

  task automatic expect_mask(input int exp, input string req);
    logic [CW-1:0] d;
    rd_reg(1'b1, d);
    check(d == CW'(exp), req, d, exp);
  endtask

  task automatic t_reset();
    check(irq == 1'b0, "R1 irq low", irq, 0);
    check(rsp_valid == 1'b0, "R1 rsp_valid low", rsp_valid, 0);
    expect_chan(0, "R1 empty list");
    expect_mask(0, "R4 mask after zero");
  endtask

  task automatic t_unarmed();
    pulse(4'b0101, 4'b1010, '0, '0, '0);
    @(negedge clk);
    check(irq == 1'b0, "R5 unarmed no irq", irq, 0);
    expect_chan(0, "R5 unarmed no entry");
  endtask

  task automatic t_closed();
    pulse('0, '0, 4'b0100, '0, '0);
    check(irq == 1'b1, "R6 closed irq", irq, 1);
    expect_chan(3, "R2 closed slot 2");
    expect_mask(4, "R3 closed mask");
    expect_chan(0, "R4 terminator");
    check(irq == 1'b0, "R9 irq low after end", irq, 0);
  endtask

  task automatic t_order_merge();
    pulse('0, '0, '0, 4'b0010, 4'b1000);
    pulse(4'b0010, '0, '0, '0, '0);
    pulse('0, 4'b1010, '0, '0, '0);   // slot 1 write unarmed
    pulse('0, '0, 4'b1000, '0, '0);
    check(irq == 1'b1, "R9 irq pending", irq, 1);
    expect_chan(2, "R2 lowest first");
    expect_mask(1, "R3 readable only");
    expect_chan(4, "R2 ascending");
    expect_mask(6, "R8 merged write+closed");
    expect_chan(0, "R4 end");
    check(irq == 1'b0, "R9 irq cleared", irq, 0);
  endtask

  task automatic t_one_shot();
    pulse('0, '0, '0, 4'b0001, '0);
    pulse(4'b0001, '0, '0, '0, '0);
    expect_chan(1, "R7 first accepted");
    expect_mask(1, "R7 first mask");
    expect_chan(0, "R7 end");
    pulse(4'b0001, '0, '0, '0, '0);
    @(negedge clk);
    check(irq == 1'b0, "R7 second dropped irq", irq, 0);
    expect_chan(0, "R7 second dropped list");
  endtask

  task automatic t_same_cycle();
    pulse('0, 4'b0100, '0, '0, 4'b0100);
    check(irq == 1'b1, "R12 same-cycle irq", irq, 1);
    expect_chan(3, "R12 same-cycle entry");
    expect_mask(2, "R12 write mask");
    expect_chan(0, "R12 end");
  endtask

  task automatic t_hold();
    pulse('0, '0, 4'b1010, '0, '0);
    expect_chan(2, "R10 first");
    pulse('0, '0, 4'b0001, '0, '0);    // arrives mid-drain
    expect_mask(4, "R10 first mask");
    expect_chan(4, "R10 held not in list");
    expect_mask(4, "R10 second mask");
    expect_chan(0, "R10 terminator");
    check(irq == 1'b1, "R10 irq stays high", irq, 1);
    expect_chan(1, "R10 held reported");
    expect_mask(4, "R10 held mask");
    expect_chan(0, "R10 final end");
    check(irq == 1'b0, "R9 irq low final", irq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_unarmed();
    t_closed();
    t_order_merge();
    t_one_shot();
    t_same_cycle();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule